// File: doc/BRIEF.md
# Competitive Activity Step Engine

This block holds the activity vector of one group of N mutually inhibiting neurons. Each time it is asked, it advances that vector by one discrete step of a competitive Lotka-Volterra equation, using Q8.8 fixed-point arithmetic. Each neuron's new activity is its old activity plus the step size times the sum of a noise sample and a growth term. The growth term is the time constant times the neuron's own activity times the difference between its bias and an inhibition-weighted sum of every activity in the group, the neuron's own included.

Weights live in a small register file. The self-weight of every neuron is fixed at one, and only off-diagonal entries can be written. The weighted sums are formed with a single multiply-accumulate unit that serves every (row, column) pair in turn. New activities are collected in a shadow vector and committed all at once, so every row of a step sees the same old vector. A one-cycle done pulse marks each commit. An optional per-neuron pseudo-random noise source adds a value bounded by a programmable amplitude. A load port sets the activity vector directly, which serves as the recall cue.

Top module: `lv_step_engine`

## Requirements
- R1: While reset is asserted and after it is released, all activities read 0, busy_o is 0 and done_o is 0.
- R2: Each step computes, per neuron i with all values signed Q8.8: S = sum over j of mul(w_ij, x_j); d = sat(b_i - S); g = mul(mul(tau, x_i), d); x_i' = sat(x_i + mul(dt, sat(g + v_i))). mul(a,b) is (a*b) arithmetically shifted right by 8 and then saturated. S is summed at full width.
- R3: The self-weight w_ii always reads as 1.0 (0x0100). A write to a diagonal address has no effect.
- R4: Weight writes address row = receiving neuron i and column = source neuron j. A negative value written off the diagonal is stored as 0.
- R5: A new activity below zero is stored as 0, and a loaded negative activity is also stored as 0. No activity is ever negative.
- R6: Every product and sum saturates to 0x7FFF or 0x8000 and never wraps.
- R7: With noise enabled, each v_i lies in [-eps, eps]. With noise disabled, or with eps = 0, v_i is 0.
- R8: With noise disabled, a neuron whose activity is 0 stays 0 whatever its bias.
- R9: A step accepted while idle keeps busy_o high for N*N+1 cycles. The new vector appears on act_o in the same cycle as the one-cycle done_o pulse.
- R10: step_i and load_i are ignored while busy_o is high. They change neither the result nor the number of done pulses.
- R11: When load_i and step_i are both high in an idle cycle, the load is taken and the step is dropped.
- R12: act_o changes only on a commit or on an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Request one update step |
| load_i | input | 1 | Load act vector from load_act_i |
| load_act_i | input | N*16 | Activity vector to load, neuron k at bits [16k+15:16k] |
| bias_i | input | N*16 | Per-neuron bias, same packing |
| w_we_i | input | 1 | Weight write enable |
| w_row_i | input | IDX_W | Receiving neuron index of the write |
| w_col_i | input | IDX_W | Source neuron index of the write |
| w_data_i | input | 16 | Weight value, Q8.8 |
| tau_i | input | 16 | Time constant, Q8.8 |
| dt_i | input | 16 | Step size, Q8.8 |
| eps_i | input | 16 | Noise amplitude, Q8.8 (negative taken as 0) |
| noise_en_i | input | 1 | Enable the noise term |
| act_o | output | N*16 | Current activity vector |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle pulse when the new vector is committed |

## Verification
Two kinds of request can meet in one cycle, and the bench provokes both. In the first, load_i and step_i are raised together in an idle cycle. The bench then expects the loaded vector on act_o, busy_o still low and no done pulse in the following cycles. In the second, a step and a load arrive together while a step is already running. The bench judges this by comparing the committed vector with its own model of the undisturbed step, and by counting that exactly one done pulse appears.

// File: rtl/lv_pkg.sv
package lv_pkg;
  localparam int Q_W    = 16;
  localparam int Q_FRAC = 8;

  typedef logic signed [Q_W-1:0] q_t;

  localparam q_t Q_ONE = 16'sh0100;
  localparam q_t Q_MAX = 16'sh7FFF;
  localparam q_t Q_MIN = q_t'(16'h8000);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_COMMIT} st_e;

  function automatic q_t sat_q(input logic signed [39:0] v);
    if (v > 40'sd32767)       return Q_MAX;
    else if (v < -40'sd32768) return Q_MIN;
    else                      return q_t'(v[Q_W-1:0]);
  endfunction

  function automatic q_t mul_q(input q_t a, input q_t b);
    logic signed [31:0] p;
    p = 32'(a) * 32'(b);
    return sat_q(40'(p) >>> Q_FRAC);
  endfunction

  function automatic q_t add_q(input q_t a, input q_t b);
    return sat_q(40'(a) + 40'(b));
  endfunction
endpackage

// File: rtl/lv_weight_rf.sv
module lv_weight_rf
  import lv_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_row_i,
  input  logic [IDX_W-1:0] wr_col_i,
  input  q_t               wr_data_i,
  input  logic [IDX_W-1:0] rd_row_i,
  input  logic [IDX_W-1:0] rd_col_i,
  output q_t               rd_data_o
);
  localparam int CELLS = N * N;
  localparam int A_W   = (CELLS > 1) ? $clog2(CELLS) : 1;

  logic [CELLS*Q_W-1:0] w_flat;
  logic [A_W-1:0]       rd_idx;

  // negative inhibition is meaningless: clamp on write
  q_t wr_clamped;
  assign wr_clamped = wr_data_i[Q_W-1] ? '0 : wr_data_i;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (r == c) begin : g_diag
        assign w_flat[(r*N+c)*Q_W +: Q_W] = Q_ONE;
      end else begin : g_cell
        q_t cell_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) cell_q <= '0;
          else if (we_i && wr_row_i == IDX_W'(r) && wr_col_i == IDX_W'(c))
            cell_q <= wr_clamped;
        end
        assign w_flat[(r*N+c)*Q_W +: Q_W] = cell_q;

        // R4
        weight_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !cell_q[Q_W-1]);
      end
    end
  end

  assign rd_idx    = A_W'(32'(rd_row_i) * N + 32'(rd_col_i));
  assign rd_data_o = q_t'(w_flat[rd_idx*Q_W +: Q_W]);
endmodule

// File: rtl/lv_noise_gen.sv
module lv_noise_gen
  import lv_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic en_i,
  input  q_t   eps_i,
  output q_t   noise_o [N]
);
  localparam logic [15:0] TAPS = 16'hB400;

  q_t eps_c;
  assign eps_c = eps_i[Q_W-1] ? '0 : eps_i;

  for (genvar k = 0; k < N; k++) begin : g_src
    localparam logic [15:0] SEED = 16'hACE1 ^ 16'(k * 16'h1F35 + 1);
    logic [15:0]        lfsr_q;
    logic signed [31:0] scaled;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lfsr_q <= SEED;
      else if (adv_i) lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ TAPS) : (lfsr_q >> 1);
    end

    // signed random in [-1,1) times eps
    assign scaled     = 32'(signed'(lfsr_q)) * 32'(eps_c);
    assign noise_o[k] = en_i ? q_t'(scaled >>> 15) : '0;

    // R7
    noise_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (noise_o[k] <= eps_c) && (noise_o[k] >= -eps_c));
  end
endmodule

// File: rtl/lv_neuron_update.sv
module lv_neuron_update
  import lv_pkg::*;
#(
  parameter int ACC_W = 19
) (
  input  q_t                      x_i,
  input  q_t                      sigma_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  q_t                      tau_i,
  input  q_t                      dt_i,
  input  q_t                      noise_i,
  output q_t                      x_next_o
);
  logic signed [39:0] diff_w;
  q_t diff, gain, growth, drive, delta, sum;

  always_comb begin
    diff_w = 40'(sigma_i) - 40'(acc_i);
    diff   = sat_q(diff_w);
    gain   = mul_q(tau_i, x_i);
    growth = mul_q(gain, diff);
    drive  = add_q(growth, noise_i);
    delta  = mul_q(dt_i, drive);
    sum    = add_q(x_i, delta);
    x_next_o = sum[Q_W-1] ? '0 : sum;
  end
endmodule

// File: rtl/lv_step_engine.sv
module lv_step_engine
  import lv_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               load_i,
  input  logic [N*16-1:0]    load_act_i,
  input  logic [N*16-1:0]    bias_i,
  input  logic               w_we_i,
  input  logic [IDX_W-1:0]   w_row_i,
  input  logic [IDX_W-1:0]   w_col_i,
  input  logic [15:0]        w_data_i,
  input  logic [15:0]        tau_i,
  input  logic [15:0]        dt_i,
  input  logic [15:0]        eps_i,
  input  logic               noise_en_i,
  output logic [N*16-1:0]    act_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int ACC_W = Q_W + $clog2(N) + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  st_e                     state_q;
  logic [IDX_W-1:0]        row_q, col_q;
  logic signed [ACC_W-1:0] acc_q, acc_sum;
  q_t                      act_q [N];
  q_t                      nxt_q [N];
  q_t                      load_v [N];
  q_t                      bias_v [N];
  q_t                      noise_v [N];
  q_t                      w_rd, prod, upd;
  logic                    done_q;

  for (genvar k = 0; k < N; k++) begin : g_pack
    assign load_v[k]          = q_t'(load_act_i[k*Q_W +: Q_W]);
    assign bias_v[k]          = q_t'(bias_i[k*Q_W +: Q_W]);
    assign act_o[k*Q_W +: Q_W] = act_q[k];

    // R5
    act_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_q[k][Q_W-1]);
  end

  lv_weight_rf #(.N(N), .IDX_W(IDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (w_we_i),
    .wr_row_i  (w_row_i),
    .wr_col_i  (w_col_i),
    .wr_data_i (q_t'(w_data_i)),
    .rd_row_i  (row_q),
    .rd_col_i  (col_q),
    .rd_data_o (w_rd)
  );

  lv_noise_gen #(.N(N)) u_noise (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (state_q == ST_COMMIT),
    .en_i    (noise_en_i),
    .eps_i   (q_t'(eps_i)),
    .noise_o (noise_v)
  );

  // single MAC: one (row, col) term per cycle
  assign prod    = mul_q(w_rd, act_q[col_q]);
  assign acc_sum = acc_q + ACC_W'(prod);

  lv_neuron_update #(.ACC_W(ACC_W)) u_upd (
    .x_i      (act_q[row_q]),
    .sigma_i  (bias_v[row_q]),
    .acc_i    (acc_sum),
    .tau_i    (q_t'(tau_i)),
    .dt_i     (q_t'(dt_i)),
    .noise_i  (noise_v[row_q]),
    .x_next_o (upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < N; k++) begin
        act_q[k] <= '0;
        nxt_q[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            for (int k = 0; k < N; k++) act_q[k] <= load_v[k][Q_W-1] ? '0 : load_v[k];
          end else if (step_i) begin
            state_q <= ST_RUN;
            row_q   <= '0;
            col_q   <= '0;
            acc_q   <= '0;
          end
        end
        ST_RUN: begin
          if (col_q == LAST) begin
            nxt_q[row_q] <= upd;
            acc_q        <= '0;
            col_q        <= '0;
            if (row_q == LAST) state_q <= ST_COMMIT;
            else               row_q   <= row_q + 1'b1;
          end else begin
            acc_q <= acc_sum;
            col_q <= col_q + 1'b1;
          end
        end
        ST_COMMIT: begin
          for (int k = 0; k < N; k++) act_q[k] <= nxt_q[k];
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  // R12
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_o) |-> (done_o || $past(load_i && !busy_o)));

  // R10
  step_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && (step_i || load_i)) |=> busy_o);
endmodule

// File: tb/lv_step_engine_bench.sv
module lv_step_engine_bench;
  localparam int N = 4;
  localparam int W = 16;
  localparam int HALF = 2500; // 200 MHz at 1 ps time unit
  localparam int NV = 5;

  // stimulus table: activities, biases, tau, dt (Q8.8)
  localparam logic [15:0] TX [NV][N] = '{
    '{16'h0100, 16'h0080, 16'h0040, 16'h0000},
    '{16'h0200, 16'h0200, 16'h0200, 16'h0200},
    '{16'h6400, 16'h0000, 16'h0000, 16'h0100},
    '{16'h001A, 16'h0033, 16'h004D, 16'h0066},
    '{16'h0000, 16'h0300, 16'h0000, 16'h0080}};
  localparam logic [15:0] TB [NV][N] = '{
    '{16'h0200, 16'h0100, 16'h0180, 16'h0300},
    '{16'h0100, 16'h0100, 16'h0100, 16'h0100},
    '{16'h7F00, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0080, 16'h0080, 16'h0080, 16'h0080},
    '{16'h0000, 16'h0200, 16'h0400, 16'h0100}};
  localparam logic [15:0] TT [NV] = '{16'h0100, 16'h0200, 16'h7F00, 16'h00C0, 16'h0180};
  localparam logic [15:0] TD [NV] = '{16'h0040, 16'h0080, 16'h7F00, 16'h0020, 16'h0100};

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           step_i = 1'b0, load_i = 1'b0, w_we_i = 1'b0, noise_en_i = 1'b0;
  logic [N*W-1:0] load_act_i = '0, bias_i = '0;
  logic [1:0]     w_row_i = '0, w_col_i = '0;
  logic [15:0]    w_data_i = '0, tau_i = '0, dt_i = '0, eps_i = '0;
  logic [N*W-1:0] act_o;
  logic           busy_o, done_o;

  int n_chk = 0, n_fail = 0;
  logic signed [15:0] wm [N][N];
  logic signed [15:0] xm [N];
  logic signed [15:0] bm [N];

  lv_step_engine #(.N(N)) u_lv_step_engine (
    .clk_i, .rst_ni, .step_i, .load_i, .load_act_i, .bias_i, .w_we_i,
    .w_row_i, .w_col_i, .w_data_i, .tau_i, .dt_i, .eps_i, .noise_en_i,
    .act_o, .busy_o, .done_o);

  always #HALF clk_i = ~clk_i;

  function automatic logic signed [15:0] m_sat(input longint v);
    if (v > 32767) return 16'sh7FFF;
    if (v < -32768) return 16'sh8000;
    return 16'(v);
  endfunction

  function automatic logic signed [15:0] m_mul(input logic signed [15:0] a, input logic signed [15:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return m_sat(p >>> 8);
  endfunction

  function automatic logic signed [15:0] m_next(input int i);
    longint s;
    logic signed [15:0] d, g, r;
    s = 0;
    for (int j = 0; j < N; j++) s += longint'(m_mul(wm[i][j], xm[j]));
    d = m_sat(longint'(bm[i]) - s);
    g = m_mul(m_mul(signed'(tau_i), xm[i]), d);
    r = m_sat(longint'(xm[i]) + longint'(m_mul(signed'(dt_i), g)));
    return (r < 0) ? 16'sh0000 : r;
  endfunction

  function automatic logic [15:0] act(input int k);
    return act_o[k*W +: W];
  endfunction

  task automatic chk(input string req, input logic [15:0] actual, input logic [15:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic write_w(input int r, input int c, input logic [15:0] v);
    @(negedge clk_i);
    w_we_i = 1'b1; w_row_i = 2'(r); w_col_i = 2'(c); w_data_i = v;
    @(negedge clk_i);
    w_we_i = 1'b0;
    if (r != c) wm[r][c] = v[15] ? 16'sh0000 : signed'(v);
  endtask

  task automatic set_bias(input logic [15:0] b [N]);
    for (int k = 0; k < N; k++) begin
      bias_i[k*W +: W] = b[k];
      bm[k] = signed'(b[k]);
    end
  endtask

  task automatic load_vec(input logic [15:0] x [N]);
    @(negedge clk_i);
    load_i = 1'b1;
    for (int k = 0; k < N; k++) begin
      load_act_i[k*W +: W] = x[k];
      xm[k] = x[k][15] ? 16'sh0000 : signed'(x[k]);
    end
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // starts a step, optionally disturbs it mid-run, returns cycles to done
  task automatic do_step(input bit disturb, output int cyc);
    logic signed [15:0] nx [N];
    for (int k = 0; k < N; k++) nx[k] = m_next(k);
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    chk("R9 busy after accept", 16'(busy_o), 16'd1);
    cyc = 0;
    while (!done_o && cyc < 100) begin
      if (disturb && cyc == 3) begin
        step_i = 1'b1; load_i = 1'b1; load_act_i = {N{16'h0500}};
      end else begin
        step_i = 1'b0; load_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    step_i = 1'b0; load_i = 1'b0;
    for (int k = 0; k < N; k++) xm[k] = nx[k];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R9 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cyc, dones, nz;
    logic [15:0] xv [N];
    logic [15:0] bv [N];

    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
      wm[i][j] = (i == j) ? 16'sh0100 : 16'sh0000;
    for (int k = 0; k < N; k++) begin xm[k] = 0; bm[k] = 0; end

    // R1 reset state
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < N; k++) chk("R1 act in reset", act(k), 16'h0000);
    chk("R1 busy in reset", 16'(busy_o), 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 done after reset", 16'(done_o), 16'd0);
    chk("R1 busy after reset", 16'(busy_o), 16'd0);

    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
      write_w(i, j, 16'(16'h0080 + 16'h0040 * ((i + j) % 3)));
    write_w(1, 1, 16'h0500);   // diagonal write must be dropped
    write_w(0, 1, 16'hFE00);   // negative write stored as 0

    // R3: self weight stays 1.0
    tau_i = 16'h0100; dt_i = 16'h0100;
    bv = '{16'h0000, 16'h0100, 16'h0000, 16'h0000};
    set_bias(bv);
    xv = '{16'h0000, 16'h0100, 16'h0000, 16'h0000};
    load_vec(xv);
    do_step(1'b0, cyc);
    chk("R3 diag weight one", act(1), 16'h0100);

    // R4: clamped negative weight
    bv = '{16'h0100, 16'h0100, 16'h0000, 16'h0000};
    set_bias(bv);
    xv = '{16'h0100, 16'h0100, 16'h0000, 16'h0000};
    load_vec(xv);
    do_step(1'b0, cyc);
    chk("R4 negative weight stored as zero", act(0), 16'h0100);
    for (int k = 0; k < N; k++) chk("R4 row/col model", act(k), xm[k]);

    // R2 table walk
    for (int t = 0; t < NV; t++) begin
      tau_i = TT[t]; dt_i = TD[t];
      set_bias(TB[t]);
      load_vec(TX[t]);
      do_step(1'b0, cyc);
      chk("R9 step latency", 16'(cyc), 16'(N * N + 1));
      chk("R9 idle at done", 16'(busy_o), 16'd0);
      for (int k = 0; k < N; k++) chk("R2 update", act(k), xm[k]);
      if (t == 1) chk("R5 negative result clamps", act(0), 16'h0000);
      if (t == 2) chk("R6 saturation high", act(0), 16'h7FFF);
      if (t == 4) chk("R8 zero activity stays zero", act(2), 16'h0000);
    end

    // R12: weight writes while idle leave act untouched
    xv[0] = act(0);
    write_w(2, 3, 16'h0300);
    repeat (5) @(negedge clk_i);
    chk("R12 act held while idle", act(0), xv[0]);

    // R5: loaded negative clamps
    xv = '{16'hFF00, 16'h0100, 16'h8000, 16'h0000};
    load_vec(xv);
    chk("R5 load negative clamps", act(0), 16'h0000);
    chk("R5 load most negative clamps", act(2), 16'h0000);
    chk("R5 load positive kept", act(1), 16'h0100);

    // R11: load and step together
    @(negedge clk_i);
    load_i = 1'b1; step_i = 1'b1;
    load_act_i = {16'h0040, 16'h0030, 16'h0020, 16'h0010};
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    chk("R11 step dropped", 16'(busy_o), 16'd0);
    chk("R11 load taken", act(0), 16'h0010);
    chk("R11 load taken", act(3), 16'h0040);
    dones = 0;
    repeat (20) begin @(negedge clk_i); if (done_o) dones++; end
    chk("R11 no done pulse", 16'(dones), 16'd0);
    for (int k = 0; k < N; k++) xm[k] = signed'(16'(16'h0010 * (k + 1)));

    // R10: step and load while busy ignored
    tau_i = 16'h0100; dt_i = 16'h0080;
    bv = '{16'h0100, 16'h0200, 16'h0080, 16'h0100};
    set_bias(bv);
    do_step(1'b1, cyc);
    chk("R10 latency unchanged", 16'(cyc), 16'(N * N + 1));
    for (int k = 0; k < N; k++) chk("R10 result undisturbed", act(k), xm[k]);
    dones = 0;
    repeat (25) begin @(negedge clk_i); if (done_o) dones++; end
    chk("R10 no extra done", 16'(dones), 16'd0);

    // R7: noise bounded by eps
    noise_en_i = 1'b1; eps_i = 16'h0080; dt_i = 16'h0100;
    nz = 0;
    xv = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    for (int s = 0; s < 6; s++) begin
      load_vec(xv);
      do_step(1'b0, cyc);
      for (int k = 0; k < N; k++) begin
        chk("R7 noise within eps", 16'(act(k) <= 16'h0080), 16'd1);
        if (act(k) != 0) nz++;
      end
    end
    chk("R7 noise active", 16'(nz > 0), 16'd1);
    eps_i = 16'h0000;
    load_vec(xv);
    do_step(1'b0, cyc);
    for (int k = 0; k < N; k++) chk("R7 zero eps gives no noise", act(k), 16'h0000);
    noise_en_i = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule